// File: doc/BRIEF.md
# Sequential Booth Multiplier for Q8.8 Fixed-Point Operands

This block multiplies two signed two's-complement fixed-point values, each 16 bits wide with 8 integer bits and 8 fractional bits. It works one multiplier bit per clock. Each step looks at the lowest bit still waiting in the multiplier register together with the bit shifted out on the step before. From that pair it adds the multiplicand to the upper half of a running accumulator, subtracts it, or leaves the accumulator alone. The whole accumulator, multiplier and previous-bit chain then shifts right by one place, keeping the sign.

A caller pulses `start` for one cycle with both operands present. The block copies them and raises `busy`. Sixteen clock cycles later it lowers `busy` and raises `done` for a single cycle. The result appears in two forms. The first is the full 32-bit product with 16 integer and 16 fractional bits. The second is a 16-bit result that drops the eight lowest fractional bits and wraps on overflow. Both values stay put until the next accepted start.

Top module: `fxm_booth_mul`

## Requirements
- R1: After reset `busy` and `done` are 0, and `product` and `product_q` are all zeros.
- R2: When `start` is high at a clock edge while `busy` is low, the operands are captured at that edge and `busy` is high from the next cycle.
- R3: `busy` stays high for exactly 16 cycles. In the cycle after it falls, `done` is high for exactly one cycle and `busy` is low. Counted from the edge that accepted `start`, `done` is first seen high after 17 rising edges.
- R4: When `done` is high, `product` equals the exact signed product of `a_in` × `b_in` as captured at start, in two's complement. Read as fixed point, it has 16 fractional bits.
- R5: The most negative operand pair, -32768 × -32768, gives `product` = 0x40000000 with no overflow.
- R6: `product_q` equals `product` bits [23:8]. That keeps 8 fractional bits and drops the rest by truncation, with no saturation (0x7FFF × 0x7FFF gives 0xFF00).
- R7: A `start` pulse while `busy` is high is ignored. The running operation keeps its timing and its result.
- R8: While `busy` is low and no start is accepted, `product` and `product_q` hold their value.
- R9: Changes on `a_in` and `b_in` while `busy` is high have no effect on the result.
- R10: A zero operand gives a zero product, whatever the other operand is. -32768 × 1 gives 0xFFFF8000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a multiplication |
| a_in | input | 16 | Multiplicand, signed Q8.8 |
| b_in | input | 16 | Multiplier, signed Q8.8 |
| busy | output | 1 | High while the 16 iteration steps run |
| done | output | 1 | One-cycle pulse when the result is valid |
| product | output | 32 | Full signed product, Q16.16 |
| product_q | output | 16 | Product truncated to 8 fractional bits |

## Verification
The assertions assume that `start` is a clean synchronous level sampled at the rising edge. They make no assumption about how `start` relates to `busy`, because the block itself must absorb a start that arrives during a run. The bench drives every input on the falling edge, so each value is stable at the sampling edge. It deliberately raises `start` and changes the operands in the middle of a run, so that the rule on ignoring requests is exercised and not merely assumed.

// File: rtl/fxm_pkg.sv
package fxm_pkg;
   typedef enum logic [1:0] {
      BOOTH_SKIP = 2'd0,
      BOOTH_ADD  = 2'd1,
      BOOTH_SUB  = 2'd2
   } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
   import fxm_pkg::*;
(
   input  logic      cur_bit,
   input  logic      prev_bit,
   output booth_op_e op
);
   always_comb begin
      unique case ({cur_bit, prev_bit})
         2'b01:   op = BOOTH_ADD;
         2'b10:   op = BOOTH_SUB;
         default: op = BOOTH_SKIP;
      endcase
   end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
   import fxm_pkg::*;
#(
   parameter int W          = 16,
   parameter bit SHARED_ADD = 1'b1
)(
   input  logic [W:0]   acc,
   input  logic [W-1:0] mcand,
   input  booth_op_e    op,
   output logic [W:0]   sum
);
   localparam int XW = W + 1;
   logic [XW-1:0] mc_ext;

   assign mc_ext = {mcand[W-1], mcand};

   generate
      if (SHARED_ADD) begin : g_shared
         logic [XW-1:0] opnd;
         logic          cin;
         always_comb begin
            opnd = '0;
            cin  = 1'b0;
            if (op == BOOTH_ADD) begin
               opnd = mc_ext;
            end else if (op == BOOTH_SUB) begin
               opnd = ~mc_ext;
               cin  = 1'b1;
            end
         end
         assign sum = acc + opnd + {{(XW-1){1'b0}}, cin};
      end else begin : g_split
         logic [XW-1:0] plus_v, minus_v;
         assign plus_v  = acc + mc_ext;
         assign minus_v = acc - mc_ext;
         always_comb begin
            unique case (op)
               BOOTH_ADD: sum = plus_v;
               BOOTH_SUB: sum = minus_v;
               default:   sum = acc;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
   parameter int STEPS = 16
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic busy,
   output logic done
);
   localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
   localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

   logic [CW-1:0] cnt_q;

   assign load = start & ~busy;
   assign step = busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         cnt_q <= '0;
      end else begin
         done <= 1'b0;
         if (busy) begin
            if (cnt_q == LAST) begin
               busy  <= 1'b0;
               done  <= 1'b1;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= '0;
         end
      end
   end
endmodule

// File: rtl/fxm_booth_mul.sv
module fxm_booth_mul
   import fxm_pkg::*;
#(
   parameter int OPW        = 16,
   parameter int FRAC       = 8,
   parameter int OUT_FRAC   = 8,
   parameter bit SHARED_ADD = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [OPW-1:0]     a_in,
   input  logic [OPW-1:0]     b_in,
   output logic               busy,
   output logic               done,
   output logic [2*OPW-1:0]   product,
   output logic [OPW-1:0]     product_q
);
   localparam int PW   = 2 * OPW;
   localparam int DROP = 2 * FRAC - OUT_FRAC;

   generate
      if (OPW < 2)               begin : g_bad_w  $error("OPW must be at least 2");           end
      if (FRAC >= OPW)           begin : g_bad_f  $error("FRAC must be below OPW");           end
      if (OUT_FRAC > 2 * FRAC)   begin : g_bad_o  $error("OUT_FRAC exceeds product fraction"); end
      if (DROP + OPW > PW)       begin : g_bad_d  $error("truncated window leaves product");   end
   endgenerate

   logic          load, step;
   logic [OPW:0]  acc_q, sum;
   logic [OPW-1:0] mq_q, mcand_q;
   logic          prev_q;
   booth_op_e     op;

   booth_seq_ctrl #(.STEPS(OPW)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .load  (load),
      .step  (step),
      .busy  (busy),
      .done  (done)
   );

   booth_recode u_rec (
      .cur_bit  (mq_q[0]),
      .prev_bit (prev_q),
      .op       (op)
   );

   booth_addsub #(.W(OPW), .SHARED_ADD(SHARED_ADD)) u_as (
      .acc   (acc_q),
      .mcand (mcand_q),
      .op    (op),
      .sum   (sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         mq_q    <= '0;
         mcand_q <= '0;
         prev_q  <= 1'b0;
      end else if (load) begin
         acc_q   <= '0;
         mq_q    <= b_in;
         mcand_q <= a_in;
         prev_q  <= 1'b0;
      end else if (step) begin
         acc_q  <= {sum[OPW], sum[OPW:1]};
         mq_q   <= {sum[0], mq_q[OPW-1:1]};
         prev_q <= mq_q[0];
      end
   end

   assign product = {acc_q[OPW-1:0], mq_q};

   generate
      if (DROP == 0) begin : g_nodrop
         assign product_q = product[OPW-1:0];
      end else begin : g_drop
         assign product_q = product[DROP+OPW-1:DROP];
      end
   endgenerate
endmodule

// File: rtl/fxm_booth_mul_chk.sv
module fxm_booth_mul_chk #(
   parameter int OPW   = 16,
   parameter int STEPS = 16
)(
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic [2*OPW-1:0] product
);
   logic [31:0] busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     busy_len <= '0;
      else if (busy)  busy_len <= busy_len + 1;
      else            busy_len <= '0;
   end

   a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> busy);

   a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r3_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r3_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_len == STEPS));

   a_r3_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start |=> (busy || done));

   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !start |=> $stable(product));
endmodule

bind fxm_booth_mul fxm_booth_mul_chk #(.OPW(OPW), .STEPS(OPW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .product (product)
);

// File: tb/fxm_booth_mul_test.sv
module fxm_booth_mul_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] a_in = '0, b_in = '0;
   logic        busy, done;
   logic [31:0] product;
   logic [15:0] product_q;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   fxm_booth_mul uut (
      .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
      .busy(busy), .done(done), .product(product), .product_q(product_q)
   );

   // behavioural reference model, updated on every edge
   logic        m_busy = 1'b0, m_done = 1'b0;
   int          m_cnt = 0;
   logic [31:0] m_pend = '0, m_prod = '0;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (!rst_n) begin
         m_busy <= 1'b0; m_done <= 1'b0; m_cnt <= 0; m_prod <= '0;
      end else begin
         m_done <= 1'b0;
         if (m_busy) begin
            m_cnt <= m_cnt + 1;
            if (m_cnt == 15) begin
               m_busy <= 1'b0; m_done <= 1'b1; m_prod <= m_pend;
            end
         end else if (start) begin
            m_busy <= 1'b1; m_cnt <= 0;
            m_pend <= 32'($signed(a_in) * $signed(b_in));
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // compare against the model on every falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2/R3 busy", 32'(busy), 32'(m_busy));
         chk("R3 done", 32'(done), 32'(m_done));
         if (!m_busy) begin
            chk("R4/R8 product", product, m_prod);
            chk("R6 product_q", 32'(product_q), 32'(m_prod[23:8]));
         end
      end
   end

   task automatic mul(input logic [15:0] a, input logic [15:0] b,
                      input logic [31:0] exp, input string tag);
      int n = 0;
      @(negedge clk);
      a_in = a; b_in = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 1;
      while (!done && n < 40) begin
         @(negedge clk);
         n++;
      end
      chk({tag, " latency"}, 32'(n), 32'd17);
      chk(tag, product, exp);
      chk({tag, " trunc"}, 32'(product_q), 32'(exp[23:8]));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 busy", 32'(busy), 32'd0);
      chk("R1 done", 32'(done), 32'd0);
      chk("R1 product", product, 32'd0);
      chk("R1 product_q", 32'(product_q), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      mul(16'h0100, 16'h0100, 32'h0001_0000, "R4 one_x_one");
      mul(16'h8000, 16'h8000, 32'h4000_0000, "R5 min_x_min");
      mul(16'h7FFF, 16'h7FFF, 32'h3FFF_0001, "R6 max_x_max");
      chk("R6 wrap value", 32'(product_q), 32'h0000_FF00);
      mul(16'h8000, 16'h0001, 32'hFFFF_8000, "R10 min_x_one");
      mul(16'h0000, 16'hA5C3, 32'h0000_0000, "R10 zero_x_any");
      mul(16'h1234, 16'h0000, 32'h0000_0000, "R10 any_x_zero");
      mul(16'hFF80, 16'h0200, 32'hFFFF_0000, "R4 neg_half_x_two");

      for (int i = 0; i < 40; i++) begin
         logic [15:0] ra, rb;
         ra = 16'($urandom);
         rb = 16'($urandom);
         mul(ra, rb, 32'($signed(ra) * $signed(rb)), "R4 random");
      end

      // R7 and R9: start and operand changes while busy
      @(negedge clk);
      a_in = 16'h0300; b_in = 16'hFE00; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      a_in = 16'h7777; b_in = 16'h1111; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      a_in = 16'h4000;
      repeat (11) @(negedge clk);
      chk("R7 still busy", 32'(busy), 32'd1);
      @(negedge clk);
      chk("R7 done on time", 32'(done), 32'd1);
      chk("R7/R9 product", product, 32'hFFFA_0000);

      // R8: hold while idle with changing operands
      a_in = 16'h1357; b_in = 16'h2468;
      repeat (5) @(negedge clk);
      chk("R8 hold product", product, 32'hFFFA_0000);
      chk("R8 hold product_q", 32'(product_q), 32'h0000_FA00);

      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wait (cycles > 20000);
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule